// File: doc/BRIEF.md
# Single-Cycle RV32 Subset Core

This block is a 32-bit processor that completes one instruction per clock. On each edge it takes the word at the program counter from an internal instruction store and splits it into its fields. It reads two source registers, computes a result in the ALU, and may touch a word-wide internal data store. The result of an instruction is committed on the following rising edge. The supported subset is register-register add, sub, and, or, xor and signed set-less-than, plus load word, store word and branch-if-equal.

Control comes from a two-stage decode. A primary decoder looks only at the opcode and sets the write enables, the operand and write-back selects, the immediate format, and a 2-bit ALU mode. A secondary decoder converts that mode, together with funct3, into a 3-bit ALU function. For that conversion it uses opcode bit 5 and funct7 bit 5 to tell subtract apart from add.

A preload port fills either internal store. The core is held still for every cycle in which that port writes. Two read-only probe ports return one register and one data word, so that results can be checked from outside the block.

Top module: `mini_rv_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes 0 and every register clears to 0.
- R2: Opcode 0110011 with funct3 000 writes rs1+rs2 to rd when funct7 is 0000000, and writes rs1-rs2 to rd when funct7 bit 5 is set (funct7 0100000). Fields: funct7[31:25], rs2[24:20], rs1[19:15], funct3[14:12], rd[11:7], opcode[6:0].
- R3: Opcode 0110011 writes rs1 AND rs2 for funct3 111, rs1 OR rs2 for funct3 110, and rs1 XOR rs2 for funct3 100.
- R4: Opcode 0110011 with funct3 010 writes 1 to rd when rs1 is less than rs2 as signed numbers, and writes 0 otherwise.
- R5: Opcode 0110011 with funct3 001, 011 or 101 writes rs1+rs2 to rd.
- R6: Load word (opcode 0000011) writes to rd the data word at index (rs1 + sign-extended instr[31:20]) >> 2.
- R7: Store word (opcode 0100011) writes rs2 to the data word at index (rs1 + sign-extended {instr[31:25], instr[11:7]}) >> 2. It writes no register.
- R8: Branch-if-equal (opcode 1100011) sets the program counter to PC + sign-extended {instr[31], instr[7], instr[30:25], instr[11:8], 0} when rs1 equals rs2. It sets PC + 4 when they differ, and it writes no register.
- R9: Register 0 always reads as 0, and writes to it are discarded.
- R10: Any opcode outside the four listed writes neither a register nor memory, and advances the program counter by 4.
- R11: In every cycle with `pl_we` high, the program counter, the registers and the program's own stores all hold. The preload word goes to the data store when `pl_dmem` is 1 and to the instruction store when it is 0, at word index `pl_addr`.
- R12: In every cycle that is not reset, not stalled and not a taken branch, the program counter advances by 4 and stays word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pl_we | input | 1 | Preload write strobe; stalls the core |
| pl_dmem | input | 1 | Preload target: 1 data store, 0 instruction store |
| pl_addr | input | PL_AW | Preload word index |
| pl_wdata | input | 32 | Preload word |
| pc_o | output | 32 | Current program counter |
| probe_reg | input | 5 | Register index to observe |
| probe_reg_data | output | 32 | Value of the observed register |
| probe_mem_addr | input | DAW | Data-store word index to observe |
| probe_mem_data | output | 32 | Value of the observed data word |

## Verification
A preload write can arrive in the same cycle as the program's own commit: a register write-back, a store, or a program counter step. The bench causes this collision by holding `pl_we` high directly after reset. At that moment the word at address 0 is a load that would otherwise write x1. The outcome is judged at the ports. The program counter must stay at 0, x1 must still read 0, and the preloaded data word must be visible through the probe. One cycle after the strobe drops, the program counter must be 4 and x1 must hold the loaded value.

// File: rtl/mrv_pkg.sv
package mrv_pkg;

    localparam int XLEN   = 32;
    localparam int NREGS  = 32;
    localparam int RIDX_W = $clog2(NREGS);

    localparam logic [6:0] OPC_LOAD  = 7'b0000011;
    localparam logic [6:0] OPC_STORE = 7'b0100011;
    localparam logic [6:0] OPC_REGOP = 7'b0110011;
    localparam logic [6:0] OPC_BRANCH = 7'b1100011;

    typedef enum logic [2:0] {
        FN_ADD = 3'b000,
        FN_SUB = 3'b001,
        FN_AND = 3'b010,
        FN_OR  = 3'b011,
        FN_SLT = 3'b101,
        FN_XOR = 3'b111
    } alu_fn_e;

    typedef enum logic [1:0] {
        MODE_ADD   = 2'b00,
        MODE_SUB   = 2'b01,
        MODE_FIELD = 2'b10
    } alu_mode_e;

    typedef enum logic [1:0] {
        IMMF_I = 2'b00,
        IMMF_S = 2'b01,
        IMMF_B = 2'b10
    } imm_fmt_e;

    typedef struct packed {
        logic [6:0] funct7;
        logic [4:0] rs2;
        logic [4:0] rs1;
        logic [2:0] funct3;
        logic [4:0] rd;
        logic [6:0] opcode;
    } instr_t;

    typedef struct packed {
        logic      reg_we;
        logic      mem_we;
        logic      branch;
        logic      use_imm;
        logic      wb_mem;
        imm_fmt_e  imm_fmt;
        alu_mode_e alu_mode;
    } ctrl_t;

    function automatic logic [XLEN-1:0] expand_imm(input instr_t ins, input imm_fmt_e fmt);
        logic [31:0] w;
        w = ins;
        case (fmt)
            IMMF_S:  return {{20{w[31]}}, w[31:25], w[11:7]};
            IMMF_B:  return {{19{w[31]}}, w[31], w[7], w[30:25], w[11:8], 1'b0};
            default: return {{20{w[31]}}, w[31:20]};
        endcase
    endfunction

endpackage

// File: rtl/mrv_decode.sv
module mrv_decode
    import mrv_pkg::*;
(
    input  instr_t  ins,
    output ctrl_t   ctrl,
    output alu_fn_e alu_fn
);

    // Primary decode: opcode only
    always_comb begin
        ctrl          = '0;
        ctrl.imm_fmt  = IMMF_I;
        ctrl.alu_mode = MODE_ADD;
        case (ins.opcode)
            OPC_LOAD: begin
                ctrl.reg_we  = 1'b1;
                ctrl.use_imm = 1'b1;
                ctrl.wb_mem  = 1'b1;
            end
            OPC_STORE: begin
                ctrl.mem_we  = 1'b1;
                ctrl.use_imm = 1'b1;
                ctrl.imm_fmt = IMMF_S;
            end
            OPC_REGOP: begin
                ctrl.reg_we   = 1'b1;
                ctrl.alu_mode = MODE_FIELD;
            end
            OPC_BRANCH: begin
                ctrl.branch   = 1'b1;
                ctrl.imm_fmt  = IMMF_B;
                ctrl.alu_mode = MODE_SUB;
            end
            default: ;
        endcase
    end

    // Secondary decode: mode plus function fields
    always_comb begin
        alu_fn = FN_ADD;
        case (ctrl.alu_mode)
            MODE_SUB: alu_fn = FN_SUB;
            MODE_FIELD: begin
                case (ins.funct3)
                    3'b000:  alu_fn = (ins.opcode[5] && ins.funct7[5]) ? FN_SUB : FN_ADD;
                    3'b010:  alu_fn = FN_SLT;
                    3'b110:  alu_fn = FN_OR;
                    3'b111:  alu_fn = FN_AND;
                    3'b100:  alu_fn = FN_XOR;
                    default: alu_fn = FN_ADD;
                endcase
            end
            default: alu_fn = FN_ADD;
        endcase
    end

endmodule

// File: rtl/mrv_alu.sv
module mrv_alu
    import mrv_pkg::*;
(
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  alu_fn_e         fn,
    output logic [XLEN-1:0] y,
    output logic            zero
);

    always_comb begin
        case (fn)
            FN_SUB:  y = a - b;
            FN_AND:  y = a & b;
            FN_OR:   y = a | b;
            FN_XOR:  y = a ^ b;
            FN_SLT:  y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/mrv_regfile.sv
module mrv_regfile
    import mrv_pkg::*;
#(
    parameter int NRD = 3
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              we,
    input  logic [RIDX_W-1:0]                 waddr,
    input  logic [XLEN-1:0]                   wdata,
    input  logic [NRD-1:0][RIDX_W-1:0]        raddr,
    output logic [NRD-1:0][XLEN-1:0]          rdata
);

    logic [XLEN-1:0] regs [NREGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++) regs[i] <= '0;
        end else if (we && (waddr != '0)) begin
            regs[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = (raddr[p] == '0) ? '0 : regs[raddr[p]];
    end

endmodule

// File: rtl/mrv_wordmem.sv
module mrv_wordmem #(
    parameter int WORDS = 64,
    parameter int W     = 32,
    parameter int NRD   = 1,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic                      clk,
    input  logic                      we,
    input  logic [AW-1:0]             waddr,
    input  logic [W-1:0]              wdata,
    input  logic [NRD-1:0][AW-1:0]    raddr,
    output logic [NRD-1:0][W-1:0]     rdata
);

    logic [W-1:0] cells [WORDS];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = cells[raddr[p]];
    end

endmodule

// File: rtl/mini_rv_core.sv
module mini_rv_core
    import mrv_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    localparam int IAW   = $clog2(IMEM_WORDS),
    localparam int DAW   = $clog2(DMEM_WORDS),
    localparam int PL_AW = (IAW > DAW) ? IAW : DAW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pl_we,
    input  logic              pl_dmem,
    input  logic [PL_AW-1:0]  pl_addr,
    input  logic [31:0]       pl_wdata,
    output logic [31:0]       pc_o,
    input  logic [4:0]        probe_reg,
    output logic [31:0]       probe_reg_data,
    input  logic [DAW-1:0]    probe_mem_addr,
    output logic [31:0]       probe_mem_data
);

    logic [XLEN-1:0] pc_q, pc_next, pc_seq, pc_tgt;
    logic [XLEN-1:0] imm, opb, alu_y, wb_data, dmem_rd;
    logic            alu_zero, core_en;
    instr_t          instr;
    ctrl_t           ctrl;
    alu_fn_e         alu_fn;

    logic [0:0][IAW-1:0]      imem_ra;
    logic [0:0][XLEN-1:0]     imem_rd;
    logic [1:0][DAW-1:0]      dmem_ra;
    logic [1:0][XLEN-1:0]     dmem_rdv;
    logic [2:0][RIDX_W-1:0]   rf_ra;
    logic [2:0][XLEN-1:0]     rf_rd;

    logic            dmem_we, imem_we;
    logic [DAW-1:0]  dmem_wa;
    logic [XLEN-1:0] dmem_wd;

    assign core_en = ~pl_we;

    // Fetch
    assign imem_ra[0] = pc_q[IAW+1:2];
    assign imem_we    = pl_we & ~pl_dmem;

    mrv_wordmem #(.WORDS(IMEM_WORDS), .W(XLEN), .NRD(1)) u_imem (
        .clk   (clk),
        .we    (imem_we),
        .waddr (pl_addr[IAW-1:0]),
        .wdata (pl_wdata),
        .raddr (imem_ra),
        .rdata (imem_rd)
    );

    assign instr = instr_t'(imem_rd[0]);

    // Decode
    mrv_decode u_dec (
        .ins    (instr),
        .ctrl   (ctrl),
        .alu_fn (alu_fn)
    );

    assign imm = expand_imm(instr, ctrl.imm_fmt);

    // Register file: port 0 rs1, port 1 rs2, port 2 probe
    assign rf_ra[0] = instr.rs1;
    assign rf_ra[1] = instr.rs2;
    assign rf_ra[2] = probe_reg;

    mrv_regfile #(.NRD(3)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .we    (ctrl.reg_we & core_en),
        .waddr (instr.rd),
        .wdata (wb_data),
        .raddr (rf_ra),
        .rdata (rf_rd)
    );

    assign probe_reg_data = rf_rd[2];

    // Execute
    assign opb = ctrl.use_imm ? imm : rf_rd[1];

    mrv_alu u_alu (
        .a    (rf_rd[0]),
        .b    (opb),
        .fn   (alu_fn),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // Data store: preload wins, program store blocked while preloading
    assign dmem_ra[0] = alu_y[DAW+1:2];
    assign dmem_ra[1] = probe_mem_addr;
    assign dmem_we    = pl_we ? pl_dmem : ctrl.mem_we;
    assign dmem_wa    = pl_we ? pl_addr[DAW-1:0] : alu_y[DAW+1:2];
    assign dmem_wd    = pl_we ? pl_wdata : rf_rd[1];

    mrv_wordmem #(.WORDS(DMEM_WORDS), .W(XLEN), .NRD(2)) u_dmem (
        .clk   (clk),
        .we    (dmem_we),
        .waddr (dmem_wa),
        .wdata (dmem_wd),
        .raddr (dmem_ra),
        .rdata (dmem_rdv)
    );

    assign dmem_rd        = dmem_rdv[0];
    assign probe_mem_data = dmem_rdv[1];

    // Write-back
    assign wb_data = ctrl.wb_mem ? dmem_rd : alu_y;

    // Next PC
    assign pc_seq  = pc_q + 32'd4;
    assign pc_tgt  = pc_q + imm;
    assign pc_next = (ctrl.branch && alu_zero) ? pc_tgt : pc_seq;

    always_ff @(posedge clk) begin
        if (rst)          pc_q <= '0;
        else if (core_en) pc_q <= pc_next;
    end

    assign pc_o = pc_q;

endmodule

// File: rtl/mrv_check.sv
module mrv_check (
    input logic        clk,
    input logic        rst,
    input logic        pl_we,
    input logic [31:0] pc,
    input logic        branch,
    input logic        alu_zero,
    input logic        reg_we,
    input logic        mem_we,
    input logic [4:0]  probe_reg,
    input logic [31:0] probe_reg_data
);

    p_pc_reset_r1: assert property (@(posedge clk) rst |=> pc == 32'd0);

    p_pc_step_r12: assert property (@(posedge clk) disable iff (rst)
        (!pl_we && !branch) |=> pc == $past(pc) + 32'd4);

    p_pc_align_r12: assert property (@(posedge clk) disable iff (rst)
        pc[1:0] == 2'b00);

    p_beq_fall_r8: assert property (@(posedge clk) disable iff (rst)
        (!pl_we && branch && !alu_zero) |=> pc == $past(pc) + 32'd4);

    p_stall_hold_r11: assert property (@(posedge clk) disable iff (rst)
        pl_we |=> pc == $past(pc));

    p_x0_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (probe_reg == 5'd0) |-> probe_reg_data == 32'd0);

    p_store_noreg_r7: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !reg_we);

endmodule

bind mini_rv_core mrv_check u_mrv_check (
    .clk            (clk),
    .rst            (rst),
    .pl_we          (pl_we),
    .pc             (pc_q),
    .branch         (ctrl.branch),
    .alu_zero       (alu_zero),
    .reg_we         (ctrl.reg_we),
    .mem_we         (ctrl.mem_we),
    .probe_reg      (probe_reg),
    .probe_reg_data (probe_reg_data)
);

// File: tb/mini_rv_core_bench.sv
`timescale 1ns/1ps
module mini_rv_core_bench;

    localparam int IW  = 64;
    localparam int DW  = 64;
    localparam int PAW = 6;
    localparam int DAW = 6;

    function automatic logic [31:0] enc_r(input logic [6:0] f7, input logic [4:0] rs2,
                                          input logic [4:0] rs1, input logic [2:0] f3,
                                          input logic [4:0] rd);
        return {f7, rs2, rs1, f3, rd, 7'b0110011};
    endfunction

    function automatic logic [31:0] enc_i(input logic [6:0] op, input logic [4:0] rd,
                                          input logic [4:0] rs1, input logic [11:0] imm);
        return {imm, rs1, 3'b010, rd, op};
    endfunction

    function automatic logic [31:0] enc_s(input logic [4:0] rs2, input logic [4:0] rs1,
                                          input logic [11:0] imm);
        return {imm[11:5], rs2, rs1, 3'b010, imm[4:0], 7'b0100011};
    endfunction

    function automatic logic [31:0] enc_b(input logic [4:0] rs1, input logic [4:0] rs2,
                                          input logic [12:0] imm);
        return {imm[12], imm[10:5], rs2, rs1, 3'b000, imm[4:1], imm[11], 7'b1100011};
    endfunction

    localparam logic [6:0] LD = 7'b0000011;

    localparam int NPROG = 23;
    localparam logic [31:0] PROG [NPROG] = '{
        enc_i(LD, 5'd1, 5'd0, 12'd0),                    // 0  x1 = d[0]
        enc_i(LD, 5'd2, 5'd0, 12'd4),                    // 1  x2 = d[1]
        enc_i(LD, 5'd3, 5'd0, 12'd8),                    // 2  x3 = d[2]
        enc_i(LD, 5'd4, 5'd0, 12'd12),                   // 3  x4 = d[3]
        enc_r(7'h00, 5'd2, 5'd1, 3'b000, 5'd5),          // 4  add
        enc_r(7'h20, 5'd2, 5'd1, 3'b000, 5'd6),          // 5  sub
        enc_r(7'h00, 5'd4, 5'd3, 3'b111, 5'd7),          // 6  and
        enc_r(7'h00, 5'd4, 5'd3, 3'b110, 5'd8),          // 7  or
        enc_r(7'h00, 5'd4, 5'd3, 3'b100, 5'd9),          // 8  xor
        enc_r(7'h00, 5'd1, 5'd2, 3'b010, 5'd10),         // 9  slt -3<5
        enc_r(7'h00, 5'd2, 5'd1, 3'b010, 5'd11),         // 10 slt 5<-3
        enc_r(7'h00, 5'd2, 5'd1, 3'b001, 5'd12),         // 11 funct3 001 -> add
        enc_s(5'd6, 5'd0, 12'd16),                       // 12 d[4] = x6
        enc_i(LD, 5'd13, 5'd0, 12'd16),                  // 13 x13 = d[4]
        enc_r(7'h00, 5'd1, 5'd1, 3'b000, 5'd0),          // 14 write to x0
        enc_b(5'd1, 5'd2, 13'd8),                        // 15 not taken
        enc_r(7'h00, 5'd1, 5'd1, 3'b000, 5'd14),         // 16 x14 = 10
        enc_b(5'd5, 5'd5, 13'd8),                        // 17 taken
        enc_r(7'h00, 5'd1, 5'd1, 3'b000, 5'd15),         // 18 skipped
        enc_i(7'b0010011, 5'd16, 5'd1, 12'd5),           // 19 unsupported opcode
        enc_s(5'd7, 5'd14, 12'hFFC),                     // 20 d[1] = x7, negative offset
        enc_i(LD, 5'd17, 5'd0, 12'd4),                   // 21 x17 = d[1]
        enc_b(5'd0, 5'd0, 13'd0)                         // 22 self loop
    };

    localparam logic [31:0] DINIT [4] = '{32'd5, 32'hFFFF_FFFD, 32'h0F0F_00FF, 32'h00FF_0F0F};

    typedef struct packed {
        logic [4:0]  rg;
        logic [31:0] val;
        logic [3:0]  req;
    } exp_t;

    localparam int NEXP = 19;
    localparam exp_t EXP [NEXP] = '{
        '{5'd1,  32'd5,          4'd6},   // R6
        '{5'd2,  32'hFFFF_FFFD,  4'd6},   // R6
        '{5'd3,  32'h0F0F_00FF,  4'd6},   // R6
        '{5'd4,  32'h00FF_0F0F,  4'd6},   // R6
        '{5'd5,  32'd2,          4'd2},   // R2 add
        '{5'd6,  32'd8,          4'd2},   // R2 sub
        '{5'd7,  32'h000F_000F,  4'd3},   // R3 and
        '{5'd8,  32'h0FFF_0FFF,  4'd3},   // R3 or
        '{5'd9,  32'h0FF0_0FF0,  4'd3},   // R3 xor
        '{5'd10, 32'd1,          4'd4},   // R4 signed true
        '{5'd11, 32'd0,          4'd4},   // R4 signed false
        '{5'd12, 32'd2,          4'd5},   // R5 default add
        '{5'd13, 32'd8,          4'd6},   // R6 load after store
        '{5'd0,  32'd0,          4'd9},   // R9 x0 write discarded
        '{5'd14, 32'd10,         4'd8},   // R8 fall-through executed
        '{5'd15, 32'd0,          4'd8},   // R8 skipped by taken branch
        '{5'd16, 32'd0,          4'd10},  // R10 unsupported opcode, also R7 rd field
        '{5'd17, 32'h000F_000F,  4'd7},   // R7 store at negative offset
        '{5'd28, 32'd0,          4'd7}    // R7 store rd field not written
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             pl_we = 1'b0;
    logic             pl_dmem = 1'b0;
    logic [PAW-1:0]   pl_addr = '0;
    logic [31:0]      pl_wdata = '0;
    logic [31:0]      pc_o;
    logic [4:0]       probe_reg = '0;
    logic [31:0]      probe_reg_data;
    logic [DAW-1:0]   probe_mem_addr = '0;
    logic [31:0]      probe_mem_data;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #5 clk = ~clk;

    mini_rv_core #(.IMEM_WORDS(IW), .DMEM_WORDS(DW)) u_mini_rv_core (
        .clk            (clk),
        .rst            (rst),
        .pl_we          (pl_we),
        .pl_dmem        (pl_dmem),
        .pl_addr        (pl_addr),
        .pl_wdata       (pl_wdata),
        .pc_o           (pc_o),
        .probe_reg      (probe_reg),
        .probe_reg_data (probe_reg_data),
        .probe_mem_addr (probe_mem_addr),
        .probe_mem_data (probe_mem_data)
    );

    task automatic check(input int req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic preload(input logic dm, input int addr, input logic [31:0] data);
        pl_we    = 1'b1;
        pl_dmem  = dm;
        pl_addr  = PAW'(addr);
        pl_wdata = data;
        @(negedge clk);
        pl_we    = 1'b0;
    endtask

    function automatic logic [31:0] read_reg(input int r);
        return 32'(r);
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 5000) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected<=5000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        check(1, "pc after reset", pc_o, 32'd0);
        probe_reg = 5'd5;
        #1 check(1, "x5 after reset", probe_reg_data, 32'd0);

        // Load the program and data while reset holds
        for (int i = 0; i < NPROG; i++) preload(1'b0, i, PROG[i]);
        for (int i = 0; i < 4; i++) preload(1'b1, i, DINIT[i]);

        // Release reset; first step must be +4 (R12)
        rst = 1'b0;
        @(negedge clk);
        check(12, "pc after first step", pc_o, 32'd4);
        for (int i = 0; i < 30; i++) @(negedge clk);

        // Register results from the vector table
        for (int i = 0; i < NEXP; i++) begin
            probe_reg = EXP[i].rg;
            #1 check(int'(EXP[i].req), $sformatf("x%0d", EXP[i].rg), probe_reg_data, EXP[i].val);
        end
        probe_mem_addr = 6'd4;
        #1 check(7, "d[4] after store", probe_mem_data, 32'd8);
        probe_mem_addr = 6'd1;
        #1 check(7, "d[1] after negative-offset store", probe_mem_data, 32'h000F_000F);
        check(8, "pc parked on self branch", pc_o, 32'd88);
        @(negedge clk);
        check(8, "pc stays on taken zero-offset branch", pc_o, 32'd88);

        // R11: preload collides with a load at pc 0 right after reset
        rst = 1'b1;
        @(negedge clk);
        probe_reg = 5'd1;
        #1 check(1, "x1 cleared by second reset", probe_reg_data, 32'd0);
        check(1, "pc cleared by second reset", pc_o, 32'd0);
        rst      = 1'b0;
        pl_we    = 1'b1;
        pl_dmem  = 1'b1;
        pl_addr  = 6'd10;
        pl_wdata = 32'hCAFE_0123;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(11, "pc held during preload", pc_o, 32'd0);
            check(11, "x1 not written during preload", probe_reg_data, 32'd0);
        end
        probe_mem_addr = 6'd10;
        #1 check(11, "preloaded data word", probe_mem_data, 32'hCAFE_0123);
        pl_we = 1'b0;
        @(negedge clk);
        check(12, "pc resumes after preload", pc_o, 32'd4);
        check(6, "x1 loaded after resume", probe_reg_data, 32'd5);
        probe_reg = 5'd0;
        #1 check(9, "x0 reads zero", probe_reg_data, 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule